// File: doc/BRIEF.md
# Readback Frame Checker

This block sits on the receiving end of a serial conversion-data readback link. It takes one data bit each time the bit-enable strobe is high while chip select is held low. It assembles those bits into 24-bit frames, or into 32-bit frames when the checksum mode is on. From each frame it recovers a signed 24-bit sample, an out-of-range flag, and a verdict on the additive checksum. It also marks samples that sit at either full-scale clip code.

Two mode inputs set the frame layout. They must match the setting of the transmitter and must only change while chip select is high. The `mode_cksum` input adds a fourth checksum byte. The `mode_flag` input carries an out-of-range flag. With the checksum off, the flag takes the place of the last data bit. With the checksum on, the flag takes the place of the top bit of the checksum byte.

The transmitter may keep shifting past the first frame to send the same sample again. The checker treats each full frame length as a new frame. When `repeat_en` is set, it compares every later frame in the same chip-select window against the first one.

Top module: `rdbk_frame_chk`

## Requirements
- R1: While `cs_n` is low, each cycle with `bit_en` high shifts in one bit of `sdi`, MSB first. After 24 bits (`mode_cksum`=0) or 32 bits (`mode_cksum`=1), `frame_vld` is high for exactly the one cycle after the clock edge that took the last bit. All outputs are 0 after reset.
- R2: `sample` takes the first 24 bits of the frame, with the first bit in bit 23. It is a two's-complement value and holds until the next frame. In modes other than the one in R5, all 24 bits are data.
- R3: With `mode_cksum`=1 and `mode_flag`=0, `cksum_err` pulses together with `frame_vld` when bits 7..0 of the frame (the last byte) differ from the expected checksum. The expected checksum is (bits 31..24 + bits 23..16 + bits 15..8 + 0x9B) mod 256.
- R4: With `mode_cksum`=1 and `mode_flag`=1, only bits 6..0 of the received and expected checksums are compared. Frame bit 7 is presented on `range_flag`.
- R5: With `mode_cksum`=0 and `mode_flag`=1, frame bit 0 (the last bit received) is presented on `range_flag`, and bit 0 of `sample` reads 0.
- R6: `cksum_err` is 0 for every frame taken with `mode_cksum`=0. `range_flag` is 0 after every frame taken with `mode_flag`=0.
- R7: `clip` pulses with `frame_vld` when `sample` is 0x7FFFFF or 0x800000.
- R8: A high `cs_n` clears the bit count, so a partial frame yields no `frame_vld`. Bits offered while `cs_n` is high or `bit_en` is low are ignored.
- R9: Frames that follow one another in one low-`cs_n` window each produce `frame_vld`. With `repeat_en`=1, `rpt_mismatch` pulses with `frame_vld` for a later frame whose bits differ from the first frame of that window.
- R10: `rpt_mismatch` stays 0 while `repeat_en` is 0, and it is 0 for the first frame of every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| bit_en | input | 1 | High for one cycle per valid serial bit |
| sdi | input | 1 | Serial data |
| mode_cksum | input | 1 | Checksum byte appended (32-bit frame) |
| mode_flag | input | 1 | Out-of-range flag embedded in frame |
| repeat_en | input | 1 | Compare repeated frames to the first |
| sample | output | 24 | Recovered signed sample |
| range_flag | output | 1 | Recovered out-of-range flag |
| cksum_err | output | 1 | Checksum mismatch pulse |
| clip | output | 1 | Full-scale code pulse |
| rpt_mismatch | output | 1 | Repeat-read mismatch pulse |
| frame_vld | output | 1 | Frame complete strobe |

## Verification
The bench builds the block with its default checksum offset of 0x9B, so the hand-computed checksum vectors apply directly. Bit strobes arrive every second clock cycle, which leaves room to check that idle cycles shift nothing in. Directed frames cover all four mode combinations, both clip codes, a partial frame cut off by chip select, and matching and differing repeated reads. Randomly drawn windows with mixed modes are then compared, cycle by cycle, against the bench's bit-queue model.

// File: rtl/rdbk_frame_chk.sv
module rdbk_frame_chk #(
  parameter logic [7:0] CK_OFFSET = 8'h9B,
  parameter int         DATA_W    = 24,
  parameter int         CK_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_en,
  input  logic              sdi,
  input  logic              mode_cksum,
  input  logic              mode_flag,
  input  logic              repeat_en,
  output logic [DATA_W-1:0] sample,
  output logic              range_flag,
  output logic              cksum_err,
  output logic              clip,
  output logic              rpt_mismatch,
  output logic              frame_vld
);
  localparam int FULL_W = DATA_W + CK_W;
  localparam int CNT_W  = $clog2(FULL_W);
  localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

  logic [FULL_W-1:0] sr, word, word_m, ref_word;
  logic [CNT_W-1:0]  cnt, last_idx;
  logic              take, done, seen_first;
  logic [7:0]        b_hi, b_mid, b_lo, b_ck, ck_exp;
  logic [DATA_W-1:0] smp_nxt;
  logic              flg_nxt, err_nxt;

  assign take     = bit_en && !cs_n;
  assign last_idx = mode_cksum ? CNT_W'(FULL_W - 1) : CNT_W'(DATA_W - 1);
  assign done     = take && (cnt == last_idx);
  assign word     = {sr[FULL_W-2:0], sdi};
  assign word_m   = mode_cksum ? word : {{CK_W{1'b0}}, word[DATA_W-1:0]};

  assign b_hi   = mode_cksum ? word[31:24] : word[23:16];
  assign b_mid  = mode_cksum ? word[23:16] : word[15:8];
  assign b_lo   = mode_cksum ? word[15:8]  : word[7:0];
  assign b_ck   = word[7:0];
  assign ck_exp = b_hi + b_mid + b_lo + CK_OFFSET;

  always_comb begin
    smp_nxt = {b_hi, b_mid, b_lo};
    flg_nxt = 1'b0;
    err_nxt = 1'b0;
    case ({mode_cksum, mode_flag})
      2'b01: begin
        flg_nxt    = b_lo[0];
        smp_nxt[0] = 1'b0;
      end
      2'b10: err_nxt = (b_ck != ck_exp);
      2'b11: begin
        flg_nxt = b_ck[7];
        err_nxt = (b_ck[6:0] != ck_exp[6:0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (cs_n) begin
      cnt <= '0;
    end else if (take) begin
      sr  <= word;
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample       <= '0;
      range_flag   <= 1'b0;
      cksum_err    <= 1'b0;
      clip         <= 1'b0;
      rpt_mismatch <= 1'b0;
      frame_vld    <= 1'b0;
      ref_word     <= '0;
      seen_first   <= 1'b0;
    end else begin
      frame_vld    <= done;
      cksum_err    <= done && err_nxt;
      clip         <= done && (smp_nxt == POS_FS || smp_nxt == NEG_FS);
      rpt_mismatch <= done && seen_first && repeat_en && (word_m != ref_word);
      if (cs_n) seen_first <= 1'b0;
      if (done) begin
        sample     <= smp_nxt;
        range_flag <= flg_nxt;
        if (!seen_first) begin
          ref_word   <= word_m;
          seen_first <= 1'b1;
        end
      end
    end
  end
endmodule

module rdbk_frame_chk_sva (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic mode_cksum,
  input logic mode_flag,
  input logic repeat_en,
  input logic range_flag,
  input logic cksum_err,
  input logic clip,
  input logic rpt_mismatch,
  input logic frame_vld
);
  p_vld_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);
  p_err_with_vld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err |-> frame_vld);
  p_no_err_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !$past(mode_cksum)) |-> !cksum_err);
  p_no_flag_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !$past(mode_flag)) |-> !range_flag);
  p_clip_with_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clip |-> frame_vld);
  p_deselect_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !frame_vld);
  p_mismatch_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_mismatch |-> (frame_vld && $past(repeat_en)));
endmodule

bind rdbk_frame_chk rdbk_frame_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode_cksum(mode_cksum),
  .mode_flag(mode_flag), .repeat_en(repeat_en), .range_flag(range_flag),
  .cksum_err(cksum_err), .clip(clip), .rpt_mismatch(rpt_mismatch),
  .frame_vld(frame_vld)
);

// File: tb/rdbk_frame_chk_tb_top.sv
module rdbk_frame_chk_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, bit_en = 1'b0, sdi = 1'b0;
  logic mode_cksum = 1'b0, mode_flag = 1'b0, repeat_en = 1'b0;
  logic [23:0] sample;
  logic range_flag, cksum_err, clip, rpt_mismatch, frame_vld;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  rdbk_frame_chk dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_en(bit_en), .sdi(sdi),
    .mode_cksum(mode_cksum), .mode_flag(mode_flag), .repeat_en(repeat_en),
    .sample(sample), .range_flag(range_flag), .cksum_err(cksum_err),
    .clip(clip), .rpt_mismatch(rpt_mismatch), .frame_vld(frame_vld)
  );

  // behavioural reference model
  bit          q[$];
  int          win_idx;
  logic [31:0] first_w;
  logic [23:0] e_smp;
  logic        e_flg, e_err, e_clip, e_mis, e_vld;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); win_idx = 0; first_w = 0;
      e_smp = 0; e_flg = 0; e_err = 0; e_clip = 0; e_mis = 0; e_vld = 0;
    end else begin
      int len;
      logic [31:0] w;
      int s;
      logic [7:0] ck;
      e_vld = 0; e_err = 0; e_clip = 0; e_mis = 0;
      len = mode_cksum ? 32 : 24;
      if (cs_n) begin
        q.delete(); win_idx = 0;
      end else if (bit_en) begin
        q.push_back(sdi);
        if (q.size() == len) begin
          w = 0;
          foreach (q[i]) w = {w[30:0], q[i]};
          q.delete();
          e_vld = 1;
          if (mode_cksum) begin
            e_smp = w[31:8];
            s = w[31:24] + w[23:16] + w[15:8] + 'h9B;
            ck = s[7:0];
            if (mode_flag) begin
              e_flg = w[7];
              e_err = (w[6:0] != ck[6:0]);
            end else begin
              e_flg = 0;
              e_err = (w[7:0] != ck);
            end
          end else begin
            e_smp = w[23:0];
            e_flg = 0;
            if (mode_flag) begin
              e_flg = w[0];
              e_smp[0] = 0;
            end
          end
          e_clip = (e_smp == 24'h7FFFFF) || (e_smp == 24'h800000);
          if (win_idx == 0) first_w = w;
          else e_mis = repeat_en && (w != first_w);
          win_idx++;
        end
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (frame_vld !== e_vld || sample !== e_smp || range_flag !== e_flg ||
          cksum_err !== e_err || clip !== e_clip || rpt_mismatch !== e_mis) begin
        errors++;
        $display("FAIL R1/R2/R3/R4/R5/R7/R9 model: vld %b smp %h flg %b err %b clip %b mis %b expected %b %h %b %b %b %b",
          frame_vld, sample, range_flag, cksum_err, clip, rpt_mismatch,
          e_vld, e_smp, e_flg, e_err, e_clip, e_mis);
      end
    end
  end

  // capture of the last frame for directed checks
  int nfr = 0;
  logic [23:0] c_smp;
  logic c_flg, c_err, c_clip, c_mis;
  always @(negedge clk) if (rst_n && frame_vld) begin
    nfr++; c_smp = sample; c_flg = range_flag; c_err = cksum_err;
    c_clip = clip; c_mis = rpt_mismatch;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdi = w[i]; bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0; sdi = ~sdi;
    end
    @(negedge clk);
  endtask

  task automatic select(input logic ck, input logic fl, input logic rp);
    @(negedge clk); cs_n = 1'b1; mode_cksum = ck; mode_flag = fl; repeat_en = rp;
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic deselect();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sample", {8'h0, sample}, 0);
    chk("R1 reset pulses", {range_flag, cksum_err, clip, rpt_mismatch, frame_vld}, 0);

    select(0, 0, 0); n0 = nfr;
    send_bits(32'h00123456, 24);
    chk("R1 24-bit frame count", nfr - n0, 1);
    chk("R2 plain sample", c_smp, 24'h123456);
    chk("R6 no err no cksum", c_err, 0);
    deselect();

    select(1, 0, 0);
    send_bits(32'h12345637, 32);
    chk("R3 good checksum", {c_smp, 7'h0, c_err}, {24'h123456, 8'h00});
    send_bits(32'h12345638, 32);
    chk("R3 bad checksum", c_err, 1);
    send_bits(32'h123456B7, 32);
    chk("R3 bit7 counted without flag", c_err, 1);
    chk("R6 flag off reads 0", c_flg, 0);
    deselect();

    select(1, 1, 0);
    send_bits(32'h123456B7, 32);
    chk("R4 flag from ck bit7", {c_flg, c_err}, 2'b10);
    send_bits(32'h12345637, 32);
    chk("R4 flag clear ok", {c_flg, c_err}, 2'b00);
    send_bits(32'h123456B6, 32);
    chk("R4 7-bit mismatch", c_err, 1);
    deselect();

    select(0, 1, 0);
    send_bits(32'h00123457, 24);
    chk("R5 flag from data bit0", {c_smp, 7'h0, c_flg}, {24'h123456, 8'h01});
    send_bits(32'h00ABCDE6, 24);
    chk("R5 flag low", {c_smp, 7'h0, c_flg}, {24'hABCDE6, 8'h00});
    deselect();

    select(1, 0, 0);
    send_bits(32'h7FFFFF18, 32);
    chk("R7 positive clip", {c_clip, c_err}, 2'b10);
    send_bits(32'h80000000 | 32'h1B, 32);
    chk("R7 negative clip", c_clip, 1);
    send_bits(32'h7FFFFE17, 32);
    chk("R7 near full scale", {c_clip, c_err}, 2'b00);
    deselect();

    select(0, 0, 0); n0 = nfr;
    send_bits(32'h3FF, 10);
    deselect();
    chk("R8 partial frame dropped", nfr - n0, 0);
    @(negedge clk); bit_en = 1'b1; sdi = 1'b1;
    repeat (4) @(negedge clk);
    bit_en = 1'b0;
    chk("R8 bits ignored while deselected", nfr - n0, 0);
    select(0, 0, 0);
    send_bits(32'h00654321, 24);
    chk("R8 next frame aligned", {nfr - n0, c_smp}, {8'd1, 24'h654321});
    deselect();

    select(1, 0, 1); n0 = nfr;
    send_bits(32'h12345637, 32);
    chk("R10 first frame no mismatch", c_mis, 0);
    send_bits(32'h12345637, 32);
    chk("R9 repeat equal", c_mis, 0);
    send_bits(32'h12345737, 32);
    chk("R9 repeat differs", c_mis, 1);
    chk("R9 three frames in window", nfr - n0, 3);
    deselect();

    select(1, 0, 0);
    send_bits(32'h12345637, 32);
    send_bits(32'h99999999, 32);
    chk("R10 no mismatch when disabled", c_mis, 0);
    deselect();

    for (int k = 0; k < 60; k++) begin
      logic [31:0] w;
      int nf;
      select($urandom_range(1), $urandom_range(1), $urandom_range(1));
      w = $urandom;
      nf = $urandom_range(3, 1);
      for (int j = 0; j < nf; j++) begin
        if ($urandom_range(3) == 0) w = $urandom;
        send_bits(w, mode_cksum ? 32 : 24);
      end
      deselect();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule